// File: doc/BRIEF.md
# Half-Duplex Collision Backoff Controller

This block decides what happens to one transmit attempt on a shared, half-duplex Ethernet segment. A MAC tells it when a frame starts and when the frame has been sent. The PHY reports collisions. The controller counts bit times from a bit-rate enable, so it works at any core clock rate. It uses this count to separate an ordinary collision, one inside the first slot of the frame, from a late one.

After an ordinary collision the controller aborts the frame. It then waits a random number of slot times and asks the MAC to try again. The random number comes from a free-running 16-bit LFSR. Its range doubles with each collision on the same frame, up to a ceiling. The controller gives up on a frame and discards it in these cases:
- the collision budget is used up;
- single-try mode is selected;
- a late collision occurs.

In full-duplex mode collisions play no part. A per-port RNG reset returns the LFSR to its seed, so a backoff sequence can be repeated.

Top module: `hd_backoff_ctrl`

## Requirements
- R1: After reset, abort_o, retry_req_o, discard_o, late_col_o and tx_ok_o are all low, and the controller is idle.
- R2: A collision seen during a frame while fewer than SLOT_BITS bit-enable ticks have passed since tx_start has three effects. abort_o pulses for one cycle one clock after the collision. discard_o stays low. retry_req_o pulses after exactly r*SLOT_BITS further bit-enable ticks. Here r is an integer with 0 <= r < 2^k, k = min(n, BACKOFF_LIMIT), and n is the count of collisions on this frame including this one.
- R3: When a frame has already been retried MAX_RETRY times and collides again, abort_o and discard_o pulse together. No retry_req_o follows. The collision count restarts, so the next frame's first collision uses k = 1.
- R4: With one_try high, the first ordinary collision pulses abort_o and discard_o together, and no retry_req_o follows.
- R5: A collision after SLOT_BITS or more bit-enable ticks of the frame pulses abort_o, discard_o and late_col_o together, and no retry_req_o follows.
- R6: While full_duplex is high, col has no effect: abort_o stays low and tx_done still yields tx_ok_o.
- R7: tx_done during a frame, with no collision in that cycle, pulses tx_ok_o one clock later. It also clears the collision count, so the next collision uses k = 1.
- R8: A pulse on rng_reset returns the backoff generator to a fixed seed. The same stimulus applied after two such pulses yields the same sequence of backoff delays.
- R9: Bit times are counted only on clocks where bit_en is high, both for the slot boundary and for the backoff delay, whatever the spacing of bit_en.
- R10: If col and tx_done arrive in the same cycle of a half-duplex frame, the collision takes priority: abort_o pulses and tx_ok_o does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One pulse per transmitted bit time |
| tx_start | input | 1 | Frame transmission begins |
| tx_done | input | 1 | Frame transmission finished |
| col | input | 1 | Collision indication from the PHY |
| full_duplex | input | 1 | High selects full-duplex (collisions ignored) |
| one_try | input | 1 | High discards on the first collision |
| rng_reset | input | 1 | Reloads the backoff LFSR seed |
| abort_o | output | 1 | Pulse: halt the current frame |
| retry_req_o | output | 1 | Pulse: backoff over, retransmit |
| discard_o | output | 1 | Pulse: drop the frame |
| late_col_o | output | 1 | Pulse: collision after the first slot |
| tx_ok_o | output | 1 | Pulse: frame sent without collision |

## Verification
The bench places collisions on both sides of the slot boundary: one tick before it and exactly at it, with bit_en spread out. A design that is off by one there would flag a late collision too early, or retry a frame it should drop. The bench runs a frame through all sixteen retries and then a seventeenth collision, and it repeats backoff sequences after RNG resets. A wrong retry limit, a counter that does not clear, or a generator that ignores its reset would give an extra retry, a range that is too wide on the next frame, or sequences that differ. Each measured backoff must be a whole number of slots within the allowed window, and that is checked with bit_en gapped as well. A delay counted in clocks rather than bit times would therefore not fit the window.

// File: rtl/hd_backoff_ctrl.sv
module hd_backoff_ctrl #(
  parameter int SLOT_BITS     = 512,
  parameter int MAX_RETRY     = 16,
  parameter int BACKOFF_LIMIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic tx_start,
  input  logic tx_done,
  input  logic col,
  input  logic full_duplex,
  input  logic one_try,
  input  logic rng_reset,
  output logic abort_o,
  output logic retry_req_o,
  output logic discard_o,
  output logic late_col_o,
  output logic tx_ok_o
);
  localparam int CW = $clog2(SLOT_BITS + 1);
  localparam int AW = $clog2(MAX_RETRY + 1);
  localparam int RW = BACKOFF_LIMIT;
  localparam int WW = RW + $clog2(SLOT_BITS) + 1;
  localparam logic [15:0] SEED = 16'hACE1;

  typedef enum logic [1:0] {S_IDLE, S_TX, S_WAIT} state_t;

  state_t        state;
  logic [CW-1:0] bit_cnt;
  logic [AW-1:0] attempts;
  logic [WW-1:0] wait_cnt;
  logic [15:0]   lfsr;
  logic [RW-1:0] mask, rnd;
  logic [WW-1:0] wait_load;
  logic [AW:0]   k;
  logic          col_hd, late, exhausted;

  assign col_hd    = col & ~full_duplex;
  assign late      = bit_cnt == CW'(SLOT_BITS);
  assign exhausted = attempts == AW'(MAX_RETRY);
  assign k         = ((attempts + 1'b1) > (AW + 1)'(BACKOFF_LIMIT)) ?
                     (AW + 1)'(BACKOFF_LIMIT) : (attempts + 1'b1);

  always_comb begin
    for (int i = 0; i < RW; i++) mask[i] = (i < int'(k));
  end

  assign rnd       = lfsr[RW-1:0] & mask;
  assign wait_load = WW'(rnd) * WW'(SLOT_BITS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      bit_cnt     <= '0;
      attempts    <= '0;
      wait_cnt    <= '0;
      lfsr        <= SEED;
      abort_o     <= 1'b0;
      retry_req_o <= 1'b0;
      discard_o   <= 1'b0;
      late_col_o  <= 1'b0;
      tx_ok_o     <= 1'b0;
    end else begin
      lfsr        <= rng_reset ? SEED : {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      abort_o     <= 1'b0;
      retry_req_o <= 1'b0;
      discard_o   <= 1'b0;
      late_col_o  <= 1'b0;
      tx_ok_o     <= 1'b0;
      case (state)
        S_IDLE: if (tx_start) begin
          state   <= S_TX;
          bit_cnt <= '0;
        end
        S_TX: begin
          if (col_hd) begin
            abort_o <= 1'b1;
            if (late) begin
              late_col_o <= 1'b1;
              discard_o  <= 1'b1;
              attempts   <= '0;
              state      <= S_IDLE;
            end else if (one_try || exhausted) begin
              discard_o <= 1'b1;
              attempts  <= '0;
              state     <= S_IDLE;
            end else begin
              attempts <= attempts + 1'b1;
              wait_cnt <= wait_load;
              state    <= S_WAIT;
            end
          end else if (tx_done) begin
            tx_ok_o  <= 1'b1;
            attempts <= '0;
            state    <= S_IDLE;
          end else if (bit_en && !late) begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        S_WAIT: begin
          if (wait_cnt == '0) begin
            retry_req_o <= 1'b1;
            state       <= S_IDLE;
          end else if (bit_en) begin
            wait_cnt <= wait_cnt - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_RETRY_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    retry_req_o |-> $past(state == S_WAIT)); // R2
  AST_ATTEMPT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    int'(attempts) <= MAX_RETRY); // R3
  AST_DISCARD_NO_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    discard_o |-> !retry_req_o && abort_o); // R3
  AST_ONE_TRY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(one_try) && abort_o) |-> discard_o); // R4
  AST_LATE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    late_col_o |-> discard_o && abort_o); // R5
  AST_FD_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(full_duplex) |-> !abort_o); // R6
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({abort_o, retry_req_o, tx_ok_o})); // R10
endmodule

// File: tb/test_hd_backoff_ctrl.sv
module test_hd_backoff_ctrl;
  localparam int S   = 4;
  localparam int MR  = 16;
  localparam int LIM = 10;

  logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, tx_start = 1'b0, tx_done = 1'b0;
  logic col = 1'b0, full_duplex = 1'b0, one_try = 1'b0, rng_reset = 1'b0;
  logic abort_o, retry_req_o, discard_o, late_col_o, tx_ok_o;
  int errors = 0, checks = 0;

  hd_backoff_ctrl #(.SLOT_BITS(S), .MAX_RETRY(MR), .BACKOFF_LIMIT(LIM)) i_hd_backoff_ctrl (
    .clk, .rst_n, .bit_en, .tx_start, .tx_done, .col, .full_duplex, .one_try, .rng_reset,
    .abort_o, .retry_req_o, .discard_o, .late_col_o, .tx_ok_o);

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic start_frame();
    tx_start = 1'b1; @(negedge clk); tx_start = 1'b0;
  endtask

  task automatic send_bits(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      bit_en = 1'b1; @(negedge clk); bit_en = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic hit(output bit a, output bit d, output bit l);
    col = 1'b1; @(negedge clk); col = 1'b0;
    a = abort_o; d = discard_o; l = late_col_o;
  endtask

  task automatic wait_retry(input int div, output int w, output bit ok);
    int ticks = 0, phase = 0;
    bit last = 1'b0;
    ok = 1'b0; w = -1;
    for (int i = 0; i < 40000; i++) begin
      if (retry_req_o) begin ok = 1'b1; w = ticks - int'(last); break; end
      last = (phase % div) == 0;
      phase++;
      ticks += int'(last);
      bit_en = last;
      @(negedge clk);
    end
    bit_en = 1'b0;
  endtask

  task automatic collide_retry(input int n, input int div, input string tag, output int w);
    bit a, d, l, ok;
    int k;
    start_frame();
    hit(a, d, l);
    chk(a == 1'b1, {tag, " abort"}, a, 1);
    chk(d == 1'b0, {tag, " no discard"}, d, 0);
    wait_retry(div, w, ok);
    chk(ok, {tag, " retry seen"}, ok, 1);
    k = (n < LIM) ? n : LIM;
    chk(w % S == 0, {tag, " whole slots"}, w, (w / S) * S);
    chk(w / S < (1 << k), {tag, " slot range"}, w / S, (1 << k) - 1);
  endtask

  task automatic no_retry(input int cyc, input string tag);
    bit seen = 1'b0;
    bit_en = 1'b1;
    repeat (cyc) begin @(negedge clk); if (retry_req_o) seen = 1'b1; end
    bit_en = 1'b0;
    chk(!seen, tag, seen, 0);
  endtask

  task automatic success(input string tag);
    start_frame();
    tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
    chk(tx_ok_o == 1'b1, tag, tx_ok_o, 1);
  endtask

  task automatic t_reset();
    chk({abort_o, retry_req_o, discard_o, late_col_o, tx_ok_o} == 5'b0, "R1 reset outputs",
        {abort_o, retry_req_o, discard_o, late_col_o, tx_ok_o}, 0);
  endtask

  task automatic t_success_clears();
    int w;
    success("R7 tx_ok on done");
    for (int n = 1; n <= 3; n++) collide_retry(n, 1, "R2 backoff", w);
    success("R7 tx_ok after retries");
    collide_retry(1, 1, "R7 count cleared", w);
    success("R7 final success");
  endtask

  task automatic t_exhaust();
    int w;
    bit a, d, l;
    for (int n = 1; n <= MR; n++) collide_retry(n, 1, "R3 retry", w);
    start_frame();
    hit(a, d, l);
    chk(a && d && !l, "R3 final collision drops", {a, d, l}, 3'b110);
    no_retry(3 * S + 5, "R3 no retry after drop");
    collide_retry(1, 1, "R3 count restarted", w);
    success("R3 recover");
  endtask

  task automatic t_one_try();
    bit a, d, l;
    one_try = 1'b1;
    start_frame();
    hit(a, d, l);
    chk(a && d && !l, "R4 single try drops", {a, d, l}, 3'b110);
    no_retry(3 * S + 5, "R4 no retry");
    one_try = 1'b0;
  endtask

  task automatic t_late();
    int w;
    bit a, d, l, ok;
    start_frame();
    send_bits(S - 1, 2);
    hit(a, d, l);
    chk(a && !d && !l, "R9 one tick before slot is ordinary", {a, d, l}, 3'b100);
    wait_retry(2, w, ok);
    chk(ok && w % S == 0 && w / S < 2, "R9 gapped backoff", w, 0);
    success("R5 clear");
    start_frame();
    send_bits(S, 1);
    hit(a, d, l);
    chk(a && d && l, "R5 late collision", {a, d, l}, 3'b111);
    no_retry(3 * S + 5, "R5 no retry");
  endtask

  task automatic t_full_duplex();
    bit seen = 1'b0;
    full_duplex = 1'b1;
    start_frame();
    send_bits(S + 2, 0);
    col = 1'b1;
    repeat (4) begin @(negedge clk); if (abort_o) seen = 1'b1; end
    col = 1'b0;
    chk(!seen, "R6 collision ignored", seen, 0);
    tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
    chk(tx_ok_o == 1'b1, "R6 done still succeeds", tx_ok_o, 1);
    full_duplex = 1'b0;
  endtask

  task automatic t_same_cycle();
    int w;
    bit ok;
    start_frame();
    col = 1'b1; tx_done = 1'b1; @(negedge clk); col = 1'b0; tx_done = 1'b0;
    chk(abort_o && !tx_ok_o, "R10 collision wins", {abort_o, tx_ok_o}, 2'b10);
    wait_retry(1, w, ok);
    chk(ok, "R10 retry follows", ok, 1);
    success("R10 clear");
  endtask

  task automatic t_gapped();
    int w;
    collide_retry(1, 3, "R9 div3 n1", w);
    collide_retry(2, 3, "R9 div3 n2", w);
    collide_retry(3, 3, "R9 div3 n3", w);
    success("R9 clear");
  endtask

  task automatic t_rng();
    int ra[5], rb[5];
    rng_reset = 1'b1; @(negedge clk); rng_reset = 1'b0;
    for (int n = 1; n <= 5; n++) collide_retry(n, 1, "R8 run a", ra[n-1]);
    success("R8 clear a");
    rng_reset = 1'b1; @(negedge clk); rng_reset = 1'b0;
    for (int n = 1; n <= 5; n++) collide_retry(n, 1, "R8 run b", rb[n-1]);
    success("R8 clear b");
    for (int n = 0; n < 5; n++) chk(ra[n] == rb[n], "R8 repeatable backoff", rb[n], ra[n]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_success_clears();
    t_same_cycle();
    t_full_duplex();
    t_one_try();
    t_late();
    t_gapped();
    t_rng();
    t_exhaust();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule